// File: doc/BRIEF.md
# Descriptor Pointer Mover with Per-Destination Quotas

This block sits between one source receive ring and two destination transmit rings, the host ring and the manager ring. It forwards packets by passing buffer pointers only; packet bytes are never touched. Each descriptor carries a page pointer, first/last page markers, a two-bit destination code and a color that names the receive ring the page belongs to. The mover gathers all pages of a packet before it decides anything. It then forwards the whole packet or returns every page of it, so a destination never sees part of a packet.

Each destination may hold only a fixed number of pages from the shared reserved pool. The block tracks how many pages each destination holds. That count rises when a packet is forwarded and falls when the destination hands a page back on the freed-descriptor input. Freed pages, and the pages of packets that are not forwarded, go back to the ring named by their color. A packet that fails the quota check increments a saturating per-destination drop counter. A counter raises its interrupt from half scale upward, and reading the counter clears it.

The controller has four states. COLLECT accepts descriptors; the page with the last-page marker moves it to DECIDE. DECIDE is a single idle cycle that picks the next state. It goes to SEND when the packet fits its destination's quota, and to FREE when it does not fit or when the code is not a forwarding code. SEND and FREE emit one page per cycle and return to COLLECT after the last page.

Top module: `dpm_mover`

## Requirements
- R1: A forwarded packet appears on `out_*` one page per cycle, in arrival order, with each pointer unchanged. `out_sop` is high on the first page only and `out_eop` on the last page only.
- R2: Destination code 0 forwards to the host (`out_valid[0]`) and code 1 to the manager (`out_valid[1]`). Code 2 (discard) and code 3 (the source interface's own ring) are never forwarded. Their pages are returned at once and no drop is counted.
- R3: Every returned page asserts only `ret_valid[c]`, where c is the page's color, together with its pointer on `ret_ptr`. A page on the freed input is passed to the return port in the same cycle.
- R4: A packet of n pages is forwarded only if its destination's outstanding count plus n is at most that destination's quota. Forwarding adds n to the outstanding count.
- R5: Each accepted freed page reported by destination `fr_src` (0 host, 1 manager) lowers that destination's outstanding count by one. The count never goes below zero.
- R6: A packet that fails the quota check forwards no page. All of its pages are returned in arrival order, and the drop counter of its destination increases by one.
- R7: Drop counters are CNT_W bits wide and stop at 2^CNT_W-1.
- R8: With `rd_en` high, `rd_data` shows the counter selected by `rd_sel` (0 host, 1 manager) in that cycle, and the clock edge clears that counter.
- R9: `irq[d]` is high exactly while drop counter d is at or above 2^(CNT_W-1).
- R10: `in_ready` is high only in COLLECT. The cycle after the last page is accepted is idle, and output starts in the next cycle. `fr_ready` is low while the mover is returning pages of its own.
- R11: After reset, no valid output is high, `in_ready` and `fr_ready` are high, and all counters and outstanding counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source descriptor valid |
| in_ready | output | 1 | Mover accepts a source descriptor |
| in_ptr | input | PTR_W | Page pointer |
| in_sop | input | 1 | First page of packet |
| in_eop | input | 1 | Last page of packet |
| in_dest | input | 2 | Destination code |
| in_color | input | COLOR_W | Owning ring of the page |
| out_valid | output | 2 | Forward strobe: bit 0 host, bit 1 manager |
| out_ptr | output | PTR_W | Forwarded page pointer |
| out_sop | output | 1 | Forwarded first page |
| out_eop | output | 1 | Forwarded last page |
| fr_valid | input | 1 | Freed descriptor valid |
| fr_ready | output | 1 | Freed descriptor accepted |
| fr_ptr | input | PTR_W | Freed page pointer |
| fr_color | input | COLOR_W | Freed page color |
| fr_src | input | 1 | Destination that freed it |
| ret_valid | output | 2**COLOR_W | Return strobe per owning ring |
| ret_ptr | output | PTR_W | Returned page pointer |
| rd_en | input | 1 | Counter read strobe |
| rd_sel | input | 1 | Counter select |
| rd_data | output | CNT_W | Selected drop counter |
| irq | output | 2 | Half-scale interrupt per destination |

## Verification
The assertions assume well-formed input. Each packet has at most MAX_PAGES pages and ends with a last-page marker. A destination returns only pages it holds, so an outstanding count can never exceed its quota. The stimulus builds every packet with a length from 1 to MAX_PAGES and marks its last page. Most freed pages are ones that were actually forwarded; one extra free per destination is sent on purpose, when the count is already zero, to exercise the floor.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef enum logic [1:0] {
        DST_HOST = 2'd0,
        DST_MGR  = 2'd1,
        DST_DROP = 2'd2,
        DST_SELF = 2'd3
    } dst_e;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_DECIDE,
        ST_SEND,
        ST_FREE
    } mv_state_e;

endpackage

// File: rtl/dpm_pkt_buf.sv
module dpm_pkt_buf #(
    parameter int PTR_W   = 12,
    parameter int COLOR_W = 1,
    parameter int DEPTH   = 4,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [PTR_W-1:0]   wr_ptr,
    input  logic [COLOR_W-1:0] wr_color,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [PTR_W-1:0]   rd_ptr,
    output logic [COLOR_W-1:0] rd_color
);
    logic [PTR_W-1:0]   ptr_mem   [DEPTH];
    logic [COLOR_W-1:0] color_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ptr_mem[wr_idx]   <= wr_ptr;
            color_mem[wr_idx] <= wr_color;
        end
    end

    assign rd_ptr   = ptr_mem[rd_idx];
    assign rd_color = color_mem[rd_idx];
endmodule

// File: rtl/dpm_quota.sv
module dpm_quota #(
    parameter int QUOTA     = 6,
    parameter int MAX_PAGES = 4,
    localparam int PG_W     = $clog2(MAX_PAGES + 1),
    localparam int OCC_W    = $clog2(QUOTA + MAX_PAGES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PG_W-1:0] req_pages,
    input  logic            inc_en,
    input  logic            dec_en,
    output logic            fits
);
    logic [OCC_W-1:0] occ_q;
    logic [OCC_W-1:0] sum;

    assign fits = (occ_q + OCC_W'(req_pages)) <= OCC_W'(QUOTA);
    assign sum  = occ_q + (inc_en ? OCC_W'(req_pages) : '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (dec_en && sum != '0) begin
            occ_q <= sum - 1'b1;
        end else begin
            occ_q <= sum;
        end
    end

    AST_QUOTA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(QUOTA)); // R4
    AST_OCC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0 && dec_en && !inc_en) |=> occ_q == '0); // R5
endmodule

// File: rtl/dpm_drop_cnt.sv
module dpm_drop_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             half
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    logic [CNT_W-1:0] base;

    assign base = clr ? '0 : cnt;
    assign half = cnt[CNT_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc && base != CNT_MAX) begin
            cnt <= base + 1'b1;
        end else begin
            cnt <= base;
        end
    end

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX); // R7
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> cnt == '0); // R8
endmodule

// File: rtl/dpm_mover.sv
module dpm_mover #(
    parameter int PTR_W      = 12,
    parameter int COLOR_W    = 1,
    parameter int MAX_PAGES  = 4,
    parameter int HOST_QUOTA = 6,
    parameter int MGR_QUOTA  = 3,
    parameter int CNT_W      = 16,
    localparam int NCOLOR    = 2 ** COLOR_W,
    localparam int PG_W      = $clog2(MAX_PAGES + 1),
    localparam int IDX_W     = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [PTR_W-1:0]   in_ptr,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [1:0]         in_dest,
    input  logic [COLOR_W-1:0] in_color,
    output logic [1:0]         out_valid,
    output logic [PTR_W-1:0]   out_ptr,
    output logic               out_sop,
    output logic               out_eop,
    input  logic               fr_valid,
    output logic               fr_ready,
    input  logic [PTR_W-1:0]   fr_ptr,
    input  logic [COLOR_W-1:0] fr_color,
    input  logic               fr_src,
    output logic [NCOLOR-1:0]  ret_valid,
    output logic [PTR_W-1:0]   ret_ptr,
    input  logic               rd_en,
    input  logic               rd_sel,
    output logic [CNT_W-1:0]   rd_data,
    output logic [1:0]         irq
);
    import dpm_pkg::*;

    mv_state_e          state_q, state_d;
    logic [PG_W-1:0]    wcnt_q;
    logic [PG_W-1:0]    rdx_q;
    dst_e               dest_q;
    logic               accept;
    logic               is_fwd;
    logic               dsel;
    logic               last_page;
    logic [PTR_W-1:0]   buf_ptr;
    logic [COLOR_W-1:0] buf_color;
    logic [1:0]         fits;
    logic [1:0]         occ_inc;
    logic [1:0]         occ_dec;
    logic [1:0]         drop_inc;
    logic [1:0]         cnt_clr;
    logic [CNT_W-1:0]   cnt [2];
    logic [1:0]         half;

    assign accept    = in_valid && (state_q == ST_COLLECT);
    assign is_fwd    = (dest_q == DST_HOST) || (dest_q == DST_MGR);
    assign dsel      = dest_q[0];
    assign last_page = (rdx_q == wcnt_q - 1'b1);

    dpm_pkt_buf #(
        .PTR_W   (PTR_W),
        .COLOR_W (COLOR_W),
        .DEPTH   (MAX_PAGES)
    ) u_buf (
        .clk      (clk),
        .wr_en    (accept),
        .wr_idx   (wcnt_q[IDX_W-1:0]),
        .wr_ptr   (in_ptr),
        .wr_color (in_color),
        .rd_idx   (rdx_q[IDX_W-1:0]),
        .rd_ptr   (buf_ptr),
        .rd_color (buf_color)
    );

    for (genvar d = 0; d < 2; d++) begin : g_dest
        assign occ_inc[d]  = (state_q == ST_DECIDE) && is_fwd && (dsel == d[0]) && fits[d];
        assign drop_inc[d] = (state_q == ST_DECIDE) && is_fwd && (dsel == d[0]) && !fits[d];
        assign occ_dec[d]  = fr_valid && fr_ready && (fr_src == d[0]);
        assign cnt_clr[d]  = rd_en && (rd_sel == d[0]);

        dpm_quota #(
            .QUOTA     ((d == 0) ? HOST_QUOTA : MGR_QUOTA),
            .MAX_PAGES (MAX_PAGES)
        ) u_quota (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_pages (wcnt_q),
            .inc_en    (occ_inc[d]),
            .dec_en    (occ_dec[d]),
            .fits      (fits[d])
        );

        dpm_drop_cnt #(
            .CNT_W (CNT_W)
        ) u_drop (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (drop_inc[d]),
            .clr   (cnt_clr[d]),
            .cnt   (cnt[d]),
            .half  (half[d])
        );
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: if (accept && in_eop) state_d = ST_DECIDE;
            ST_DECIDE:  state_d = (is_fwd && fits[dsel]) ? ST_SEND : ST_FREE;
            ST_SEND:    if (last_page) state_d = ST_COLLECT;
            ST_FREE:    if (last_page) state_d = ST_COLLECT;
            default:    state_d = ST_COLLECT;
        endcase
    end

    // State and packet bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_COLLECT;
            wcnt_q  <= '0;
            rdx_q   <= '0;
            dest_q  <= DST_HOST;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_COLLECT: if (accept) begin
                    wcnt_q <= wcnt_q + 1'b1;
                    if (in_eop) dest_q <= dst_e'(in_dest);
                end
                ST_DECIDE: rdx_q <= '0;
                ST_SEND, ST_FREE: begin
                    rdx_q <= rdx_q + 1'b1;
                    if (last_page) wcnt_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_ready  = (state_q == ST_COLLECT);
        fr_ready  = (state_q != ST_FREE);
        out_valid = '0;
        out_ptr   = buf_ptr;
        out_sop   = (state_q == ST_SEND) && (rdx_q == '0);
        out_eop   = (state_q == ST_SEND) && last_page;
        ret_valid = '0;
        ret_ptr   = fr_ptr;
        if (state_q == ST_SEND) out_valid[dsel] = 1'b1;
        if (state_q == ST_FREE) begin
            ret_valid[buf_color] = 1'b1;
            ret_ptr              = buf_ptr;
        end else if (fr_valid) begin
            ret_valid[fr_color] = 1'b1;
        end
    end

    assign rd_data = rd_sel ? cnt[1] : cnt[0];
    assign irq     = half;

    AST_PKT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wcnt_q == PG_W'(MAX_PAGES - 1)) |-> in_eop); // R6
    AST_ONLY_FWD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> (dest_q == DST_HOST || dest_q == DST_MGR)); // R2
    AST_SOP_AFTER_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|out_valid) && out_sop) |-> $past(state_q) == ST_DECIDE); // R6
    AST_RET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ret_valid)); // R3
    AST_NO_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> !in_ready); // R10
endmodule

// File: tb/test_dpm_mover.sv
module test_dpm_mover;
    localparam int CLK_PERIOD = 10;
    localparam int PTR_W = 12;
    localparam int CNT_W = 4;
    localparam int HALF  = 8;
    localparam int CMAX  = 15;
    localparam int MAXP  = 4;
    localparam int QH    = 6;
    localparam int QM    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [PTR_W-1:0] in_ptr = '0;
    logic in_sop = 1'b0, in_eop = 1'b0;
    logic [1:0] in_dest = '0;
    logic [0:0] in_color = '0;
    logic [1:0] out_valid;
    logic [PTR_W-1:0] out_ptr;
    logic out_sop, out_eop;
    logic fr_valid = 1'b0, fr_ready;
    logic [PTR_W-1:0] fr_ptr = '0;
    logic [0:0] fr_color = '0;
    logic fr_src = 1'b0;
    logic [1:0] ret_valid;
    logic [PTR_W-1:0] ret_ptr;
    logic rd_en = 1'b0, rd_sel = 1'b0;
    logic [CNT_W-1:0] rd_data;
    logic [1:0] irq;

    int checks = 0, errors = 0;
    int occ[2], drops[2];
    int quota[2];
    int base = 16;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpm_mover #(.PTR_W(PTR_W), .COLOR_W(1), .MAX_PAGES(MAXP),
                .HOST_QUOTA(QH), .MGR_QUOTA(QM), .CNT_W(CNT_W)) i_dpm_mover (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_ptr(in_ptr),
        .in_sop(in_sop), .in_eop(in_eop), .in_dest(in_dest), .in_color(in_color),
        .out_valid(out_valid), .out_ptr(out_ptr), .out_sop(out_sop), .out_eop(out_eop),
        .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_ptr(fr_ptr),
        .fr_color(fr_color), .fr_src(fr_src),
        .ret_valid(ret_valid), .ret_ptr(ret_ptr),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_irq();
        int e;
        e = ((drops[1] >= HALF) ? 2 : 0) + ((drops[0] >= HALF) ? 1 : 0);
        chk(int'(irq) == e, "R9 irq", int'(irq), e);
    endtask

    task automatic send_pkt(input int n, input int dst);
        bit deliver;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(in_ready == 1'b1, "R10 in_ready in collect", int'(in_ready), 1);
            in_valid = 1'b1;
            in_ptr   = PTR_W'(base + i);
            in_sop   = (i == 0);
            in_eop   = (i == n - 1);
            in_dest  = 2'(dst);
            in_color = 1'(i % 2);
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(out_valid == 2'b00 && ret_valid == 2'b00, "R10 idle decide cycle",
            int'({out_valid, ret_valid}), 0);
        chk(in_ready == 1'b0, "R10 in_ready low in decide", int'(in_ready), 0);
        deliver = (dst < 2) && (occ[dst] + n <= quota[dst]);
        if (deliver) occ[dst] += n;
        else if (dst < 2 && drops[dst] < CMAX) drops[dst]++;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (deliver) begin
                chk(int'(out_valid) == (1 << dst), "R4 forward to destination",
                    int'(out_valid), 1 << dst);
                chk(int'(out_ptr) == base + i, "R1 pointer order", int'(out_ptr), base + i);
                chk(out_sop == (i == 0) && out_eop == (i == n - 1), "R1 sop/eop marks",
                    int'({out_sop, out_eop}), int'({(i == 0), (i == n - 1)}));
            end else begin
                chk(out_valid == 2'b00, (dst < 2) ? "R6 nothing forwarded" : "R2 not forwarded",
                    int'(out_valid), 0);
                chk(int'(ret_valid) == (1 << (i % 2)), "R3 return by color",
                    int'(ret_valid), 1 << (i % 2));
                chk(int'(ret_ptr) == base + i, "R6 returned pointer order",
                    int'(ret_ptr), base + i);
                chk(fr_ready == 1'b0, "R10 fr_ready low while freeing", int'(fr_ready), 0);
            end
        end
        base += 8;
        @(negedge clk);
        chk_irq();
    endtask

    task automatic free_one(input int src, input int ptr, input int color);
        @(negedge clk);
        fr_valid = 1'b1;
        fr_src   = 1'(src);
        fr_ptr   = PTR_W'(ptr);
        fr_color = 1'(color);
        #1;
        chk(int'(ret_valid) == (1 << color) && int'(ret_ptr) == ptr,
            "R3 freed page passed through", int'(ret_ptr), ptr);
        @(posedge clk);
        #1;
        fr_valid = 1'b0;
        if (occ[src] > 0) occ[src]--;
    endtask

    task automatic read_cnt(input int d);
        @(negedge clk);
        rd_en  = 1'b1;
        rd_sel = 1'(d);
        #1;
        chk(int'(rd_data) == drops[d], "R8 counter read", int'(rd_data), drops[d]);
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        drops[d] = 0;
        @(negedge clk);
        chk_irq();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        quota[0] = QH; quota[1] = QM;
        occ[0] = 0; occ[1] = 0; drops[0] = 0; drops[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        chk(out_valid == 2'b00 && ret_valid == 2'b00, "R11 no valid after reset",
            int'({out_valid, ret_valid}), 0);
        chk(in_ready && fr_ready, "R11 ready after reset", int'({in_ready, fr_ready}), 3);
        chk(irq == 2'b00, "R11 irq clear", int'(irq), 0);

        // Sweep every destination code against every packet length
        for (int dst = 0; dst < 4; dst++)
            for (int n = 1; n <= MAXP; n++)
                send_pkt(n, dst);

        // R5: return everything outstanding, plus one extra per destination
        for (int d = 0; d < 2; d++) begin
            int k;
            k = occ[d];
            for (int j = 0; j <= k; j++) free_one(d, 100 + j, j % 2);
        end
        read_cnt(0);
        read_cnt(1);

        // R5 floor: manager at zero takes a packet of exactly its quota
        send_pkt(QM, 1);
        // R7/R9: saturate the manager counter with quota-blocked packets
        for (int j = 0; j < 20; j++) send_pkt(1 + (j % 2), 1);
        read_cnt(1);
        // R4 host boundary: exact fill, then one page over
        send_pkt(MAXP, 0);
        send_pkt(2, 0);
        send_pkt(1, 0);
        read_cnt(0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule